// File: doc/BRIEF.md
# Serial EEPROM Command Sequencer

This block is the slave-side serial front end of a small byte-addressed non-volatile store. A host frames each access with an active-low select and clocks it with a mode-0 serial clock. Every frame opens with an 8-bit opcode. Read and write opcodes then take a 16-bit address, most significant bit first, of which only the low ten bits are used. After that come the data bytes. The block returns read data and a status byte most significant bit first, and it buffers up to one 32-byte page of write data. That page is committed to a 1024-byte register array when select rises, but only if the frame ended on a whole byte.

The serial inputs are oversampled by the system clock. A rising serial clock captures the input bit, and a falling serial clock moves the next output bit onto the data-out line. A down-counter of configurable length stands in for the program cycle. While it runs, the block reports busy and rejects new write-type opcodes, but reads and status reads are still served.

Opcodes: 0x01 writes status, 0x02 writes memory, 0x03 reads memory, 0x04 clears write enable, 0x05 reads status, 0x06 sets write enable. The status byte is laid out as bit 0 busy, bit 1 write enable, bits 3:2 two stored protect bits written by the write-status opcode from data bits 3:2, and the other bits zero.

Top module: `spi_eeprom_seq`

## Requirements
- R1: After reset the data-out enable is low, and the status byte reads 0x00 (not busy, write enable clear, protect bits zero).
- R2: After reset, no opcode is accepted until select has been seen high and then falling. Clocks sent with select held low from reset have no effect.
- R3: Opcode 0x05 returns the live status byte MSB first, and keeps returning it, byte after byte, for as long as the host keeps clocking.
- R4: Opcode 0x06 sets write enable and 0x04 clears it. After either one, all further clocks in that frame are ignored.
- R5: A memory write sent while write enable is clear changes no byte and starts no program cycle.
- R6: A read returns bytes starting at address bits 9:0, ignores address bits 15:10, auto-increments, and wraps from 0x3FF to 0x000.
- R7: Write data bytes are stored at consecutive columns within the aligned 32-byte page of the start address, wrapping inside that page. They are committed when select rises.
- R8: If the frame holds a bit count that is not a multiple of eight when select rises, the write is dropped, no program cycle starts, and write enable stays set.
- R9: A committed write or status write reads busy (status bit 0) for PROG_CYCLES clocks and clears write enable.
- R10: Write and write-status opcodes received while busy are ignored, and write enable is left as it was.
- R11: Data out is enabled only during the data phase of a read or status read. Data out changes only after a falling serial clock.
- R12: Opcode 0x01 with write enable set stores data bits 3:2 as the protect bits. Without write enable it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, valid while spi_miso_oe is high |
| spi_miso_oe | output | 1 | Data-out enable; low means the line is released (high impedance) |

## Verification
A wrong bit counter or state register shows up at the ports within one byte. A misaligned status or read byte comes back shifted, or the output enable rises or falls on the wrong bit. Errors in the page column or address shows up only when the array is read back after the program cycle, so the bench writes known patterns and reads them back through wrap points. A wrong busy or write-enable update is visible at the next status read. That read is placed both inside and after the program window.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_RDATA, ST_WDATA, ST_SRD, ST_SWR, ST_HOLD
  } seq_state_e;

  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  // status byte: {zeros, protect[1:0], write enable, busy}
  function automatic logic [7:0] pack_status(logic busy, logic wel, logic [1:0] prot);
    return {4'b0000, prot, wel, busy};
  endfunction

  // a frame ends on a byte boundary when the bit phase is back at zero
  function automatic logic frame_aligned(logic [2:0] bit_phase);
    return bit_phase == 3'd0;
  endfunction
endpackage

// File: rtl/eep_edges.sv
module eep_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic frame_open,
  output logic frame_close
);
  logic sck_q;
  logic cs_q;

  // cs_q resets low so a select held low through reset opens no frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
    end
  end

  assign sck_rise    = sck && !sck_q;
  assign sck_fall    = !sck && sck_q;
  assign frame_open  = cs_q && !cs_n;
  assign frame_close = !cs_q && cs_n;
endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
  parameter int CYCLES = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] remain;
  logic [CW:0]   run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             remain <= '0;
    else if (start)         remain <= CW'(CYCLES);
    else if (remain != '0)  remain <= remain - CW'(1);
  end

  assign busy = remain != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  // R9
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  // R9
  busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= (CW+1)'(CYCLES));
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [7:0]               rd_data,
  input  logic                     buf_clear,
  input  logic                     buf_we,
  input  logic [PAGE_W-1:0]        buf_col,
  input  logic [7:0]               buf_data,
  input  logic                     commit,
  input  logic [ADDR_W-PAGE_W-1:0] commit_page
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;

  logic [7:0]      mem  [DEPTH];
  logic [7:0]      pbuf [PAGE];
  logic [PAGE-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < PAGE; i++)
        if (mask[i]) mem[{commit_page, PAGE_W'(i)}] <= pbuf[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask <= '0;
    else if (buf_clear) mask <= '0;
    else if (buf_we)    mask[buf_col] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[buf_col] <= buf_data;
  end

  assign rd_data = mem[rd_addr];

  // R7
  commit_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (mask != '0));
endmodule

// File: rtl/spi_eeprom_seq.sv
module spi_eeprom_seq
  import eep_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int PAGE_W      = 5,
  parameter int PROG_CYCLES = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);
  localparam int PSEL_W = ADDR_W - PAGE_W;

  logic sck_rise, sck_fall, frame_open, frame_close;
  seq_state_e        state;
  logic [6:0]        sr;
  logic [2:0]        bit_ph;
  logic [7:0]        in_byte;
  logic              addr_lo_phase;
  logic [7:0]        hi_byte;
  logic              is_read;
  logic [ADDR_W-1:0] addr;
  logic [PAGE_W-1:0] col;
  logic [PSEL_W-1:0] page;
  logic              got_byte;
  logic [7:0]        wsr_byte;
  logic [7:0]        out_sr;
  logic              load_pend;
  logic              wel, busy;
  logic [1:0]        prot;
  logic [7:0]        status;
  logic [7:0]        rd_data;
  logic [15:0]       full_addr;
  logic active, byte_done, cmd_done, buf_we, aligned;
  logic commit, wsr_commit, prog_start;

  eep_edges u_edges (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .frame_open(frame_open), .frame_close(frame_close)
  );

  // named internal events
  assign in_byte    = {sr, spi_mosi};
  assign full_addr  = {hi_byte, in_byte};
  assign active     = (state != ST_IDLE) && (state != ST_HOLD);
  assign byte_done  = sck_rise && !spi_cs_n && active && (bit_ph == 3'd7);
  assign cmd_done   = byte_done && (state == ST_CMD);
  assign buf_we     = byte_done && (state == ST_WDATA);
  assign aligned    = frame_aligned(bit_ph);
  assign commit     = frame_close && (state == ST_WDATA) && got_byte && aligned;
  assign wsr_commit = frame_close && (state == ST_SWR) && got_byte && aligned;
  assign prog_start = commit || wsr_commit;
  assign status     = pack_status(busy, wel, prot);

  assign spi_miso_oe = (state == ST_RDATA) || (state == ST_SRD);
  assign spi_miso    = out_sr[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; sr <= '0; bit_ph <= '0; addr_lo_phase <= 1'b0;
      hi_byte <= '0; is_read <= 1'b0; addr <= '0; col <= '0; page <= '0;
      got_byte <= 1'b0; wsr_byte <= '0; out_sr <= '0; load_pend <= 1'b0;
    end else if (frame_open) begin
      state <= ST_CMD; bit_ph <= '0; addr_lo_phase <= 1'b0;
      got_byte <= 1'b0; load_pend <= 1'b0;
    end else if (frame_close) begin
      state <= ST_IDLE; load_pend <= 1'b0;
    end else begin
      if (sck_rise && active) begin
        sr     <= in_byte[6:0];
        bit_ph <= bit_ph + 3'd1;
      end
      if (byte_done) begin
        unique case (state)
          ST_CMD: begin
            unique case (in_byte)
              OP_READ:  begin state <= ST_ADDR; is_read <= 1'b1; end
              OP_WRITE: begin
                if (wel && !busy) begin state <= ST_ADDR; is_read <= 1'b0; end
                else state <= ST_HOLD;
              end
              OP_RDSR:  begin state <= ST_SRD; load_pend <= 1'b1; end
              OP_WRSR:  state <= (wel && !busy) ? ST_SWR : ST_HOLD;
              default:  state <= ST_HOLD;
            endcase
          end
          ST_ADDR: begin
            if (!addr_lo_phase) begin
              hi_byte       <= in_byte;
              addr_lo_phase <= 1'b1;
            end else begin
              addr <= full_addr[ADDR_W-1:0];
              if (is_read) begin
                state     <= ST_RDATA;
                load_pend <= 1'b1;
              end else begin
                state <= ST_WDATA;
                col   <= full_addr[PAGE_W-1:0];
                page  <= full_addr[ADDR_W-1:PAGE_W];
              end
            end
          end
          ST_RDATA, ST_SRD: load_pend <= 1'b1;
          ST_WDATA: begin
            col      <= col + PAGE_W'(1);
            got_byte <= 1'b1;
          end
          ST_SWR: begin
            if (!got_byte) wsr_byte <= in_byte;
            got_byte <= 1'b1;
          end
          default: ;
        endcase
      end
      if (sck_fall && spi_miso_oe) begin
        if (load_pend) begin
          load_pend <= 1'b0;
          if (state == ST_SRD) out_sr <= status;
          else begin
            out_sr <= rd_data;
            addr   <= addr + ADDR_W'(1);
          end
        end else begin
          out_sr <= {out_sr[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wel <= 1'b0;
    else if (cmd_done && in_byte == OP_WREN) wel <= 1'b1;
    else if ((cmd_done && in_byte == OP_WRDI) || prog_start) wel <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          prot <= 2'b00;
    else if (wsr_commit) prot <= wsr_byte[3:2];
  end

  eep_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(prog_start), .busy(busy)
  );

  eep_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
    .clk(clk), .rst_n(rst_n), .rd_addr(addr), .rd_data(rd_data),
    .buf_clear(frame_open), .buf_we(buf_we), .buf_col(col), .buf_data(in_byte),
    .commit(commit), .commit_page(page)
  );

  // R11
  miso_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_miso_oe && $past(spi_miso_oe) && !$past(sck_fall)) |-> $stable(spi_miso));
  // R11
  oe_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n)) |-> !spi_miso_oe);
  // R10
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> !busy);
  // R9
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> !wel);
  // R4
  hold_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && !spi_cs_n) |=> $stable(wel));
endmodule

// File: tb/spi_eeprom_seq_tb.sv
`timescale 1ns/1ps
module spi_eeprom_seq_tb;
  localparam int HALF = 4;
  localparam int PROG = 400;
  localparam logic [23:0] VEC [5] = '{
    24'h0000_11, 24'h83FF_A5, 24'h0155_3C, 24'hFC80_7E, 24'h0201_C3
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0;
  logic spi_cs_n = 1'b0;
  logic spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe;
  int errors = 0;
  int checks = 0;
  int stab_err = 0;
  bit done = 1'b0;
  logic [7:0] rbuf [8];
  logic [7:0] s;

  always #2.5 clk = ~clk;

  spi_eeprom_seq #(.ADDR_W(10), .PAGE_W(5), .PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe)
  );

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic spi_bit(input logic b, output logic r);
    spi_mosi = b;
    repeat (HALF) @(negedge clk);
    r = spi_miso;
    spi_sck = 1'b1;
    repeat (HALF) @(negedge clk);
    if (spi_miso_oe && spi_miso !== r) stab_err++;
    spi_sck = 1'b0;
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) spi_bit(tx[i], rx[i]);
  endtask

  task automatic frame_begin();
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic frame_end();
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [7:0] op);
    logic [7:0] d;
    frame_begin(); spi_byte(op, d); frame_end();
  endtask

  task automatic rd_status(output logic [7:0] st);
    logic [7:0] d;
    frame_begin(); spi_byte(8'h05, d); spi_byte(8'h00, st); frame_end();
  endtask

  task automatic wr1(input logic [15:0] a, input logic [7:0] v);
    logic [7:0] d;
    frame_begin();
    spi_byte(8'h02, d); spi_byte(a[15:8], d); spi_byte(a[7:0], d); spi_byte(v, d);
    frame_end();
  endtask

  task automatic read_n(input logic [15:0] a, input int n);
    logic [7:0] d;
    frame_begin();
    spi_byte(8'h03, d); spi_byte(a[15:8], d); spi_byte(a[7:0], d);
    for (int k = 0; k < n; k++) spi_byte(8'h00, rbuf[k]);
    frame_end();
  endtask

  task automatic wait_prog();
    repeat (PROG + 40) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic b;
    logic [15:0] a;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check8("R1 oe after reset", {7'b0, spi_miso_oe}, 8'h00);
    // R2: write enable clocked in while select low since reset
    spi_byte(8'h06, d);
    spi_cs_n = 1'b1;
    repeat (2*HALF) @(negedge clk);
    rd_status(s);
    check8("R2 no frame without select fall", s, 8'h00);
    check8("R1 status after reset", s, 8'h00);

    // R6 table of single-byte writes and read-back with junk high address bits
    for (int k = 0; k < 5; k++) begin
      a = VEC[k][23:8];
      send_cmd(8'h06);
      wr1(a, VEC[k][7:0]);
      wait_prog();
      read_n({6'h2A, a[9:0]}, 1);
      check8("R6 table read-back", rbuf[0], VEC[k][7:0]);
    end

    // R6 wrap at top of array
    read_n(16'h03FF, 2);
    check8("R6 wrap first", rbuf[0], 8'hA5);
    check8("R6 wrap second", rbuf[1], 8'h11);

    // R9 busy window, R10 write during busy
    send_cmd(8'h06);
    wr1(16'h0300, 8'h5A);
    rd_status(s);
    check8("R9 busy with enable cleared", s, 8'h01);
    send_cmd(8'h06);
    wr1(16'h0301, 8'h77);
    wait_prog();
    rd_status(s);
    check8("R10 ignored write keeps enable", s, 8'h02);
    read_n(16'h0300, 2);
    check8("R9 committed byte", rbuf[0], 8'h5A);
    check8("R10 busy write dropped", rbuf[1], 8'hFF);

    // R8 partial byte aborts
    frame_begin();
    spi_byte(8'h02, d); spi_byte(8'h01, d); spi_byte(8'h00, d); spi_byte(8'h55, d);
    spi_bit(1'b1, b); spi_bit(1'b0, b); spi_bit(1'b1, b);
    frame_end();
    rd_status(s);
    check8("R8 no program, enable kept", s, 8'h02);
    read_n(16'h0100, 1);
    check8("R8 byte unchanged", rbuf[0], 8'hFF);
    send_cmd(8'h04);

    // R5 write without enable
    wr1(16'h0101, 8'h12);
    rd_status(s);
    check8("R5 not busy", s, 8'h00);
    read_n(16'h0101, 1);
    check8("R5 byte unchanged", rbuf[0], 8'hFF);

    // R4 clocks after enable are ignored in the same frame
    frame_begin(); spi_byte(8'h06, d); spi_byte(8'h04, d); frame_end();
    rd_status(s);
    check8("R4 enable set, rest ignored", s, 8'h02);

    // R3 prolonged status read
    frame_begin();
    spi_byte(8'h05, d);
    for (int k = 0; k < 3; k++) begin
      spi_byte(8'h00, d);
      check8("R3 repeated status", d, 8'h02);
    end
    frame_end();
    send_cmd(8'h04);
    rd_status(s);
    check8("R4 enable cleared", s, 8'h00);

    // R7 page write wrapping inside page 0x020-0x03F
    send_cmd(8'h06);
    frame_begin();
    spi_byte(8'h02, d); spi_byte(8'h00, d); spi_byte(8'h3C, d);
    for (int k = 0; k < 6; k++) spi_byte(8'hD0 + 8'(k), d);
    frame_end();
    wait_prog();
    read_n(16'h0020, 3);
    check8("R7 wrapped col 0", rbuf[0], 8'hD4);
    check8("R7 wrapped col 1", rbuf[1], 8'hD5);
    check8("R7 col 2 untouched", rbuf[2], 8'hFF);
    read_n(16'h003C, 4);
    for (int k = 0; k < 4; k++) check8("R7 page tail", rbuf[k], 8'hD0 + 8'(k));

    // R12 status write
    send_cmd(8'h06);
    frame_begin(); spi_byte(8'h01, d); spi_byte(8'h0C, d); frame_end();
    rd_status(s);
    check8("R12 protect stored while busy", s, 8'h0D);
    wait_prog();
    rd_status(s);
    check8("R12 protect after cycle", s, 8'h0C);
    frame_begin(); spi_byte(8'h01, d); spi_byte(8'h00, d); frame_end();
    wait_prog();
    rd_status(s);
    check8("R12 without enable ignored", s, 8'h0C);

    // R11 output enable phases
    frame_begin();
    spi_byte(8'h03, d); spi_byte(8'h00, d);
    check8("R11 oe low in address", {7'b0, spi_miso_oe}, 8'h00);
    spi_byte(8'h20, d);
    check8("R11 oe high in data", {7'b0, spi_miso_oe}, 8'h01);
    spi_byte(8'h00, d);
    check8("R11 data byte", d, 8'hD4);
    frame_end();
    check8("R11 oe low after deselect", {7'b0, spi_miso_oe}, 8'h00);
    checks++;
    if (stab_err != 0) begin
      errors++;
      $display("FAIL R11 data out moved during high clock actual=%0d expected=0", stab_err);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule